// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes two-channel PCM audio from a three-wire serial link and turns it into parallel samples. The three wires are a frame clock that marks the channel, a bit clock, and a data line. A 2-bit format select picks one of four framings: left-justified, I2S, right-justified 16-bit or right-justified 24-bit. For every complete half-frame the block returns a 24-bit sample, a left/right tag and a one-cycle valid strobe.

All logic runs on a fast system clock. The three serial wires pass through a synchronizer and are sampled there, and data is taken on each rising edge of the bit clock. In the right-justified framings the sample is aligned to the end of the half-frame. The block holds the last bits received and reads them out when the frame clock toggles. Each framing sets a minimum number of bit clocks per half-frame. A half-frame shorter than that minimum is dropped and raises a sticky error flag. The format select is read only when the frame clock toggles.

Top module: `serial_audio_rx`

## Requirements
- R1: Format code 0 (left-justified): the first data bit of a half-frame, taken on the first bit-clock rise after the frame clock changes, is the sample MSB. Bits follow MSB first, and the first 24 bits fill sample_o[23:0]. Frame clock high is the left channel (right_o=0).
- R2: Format code 1 (I2S): the first bit of a half-frame is skipped. The next bits, up to 24, fill the sample MSB first. Frame clock low is the left channel.
- R3: Format code 2 (right-justified 16): the last 16 bits before the frame clock changes fill sample_o[23:8], with the LSB being the last bit, and sample_o[7:0]=0. Frame clock high is left.
- R4: Format code 3 (right-justified 24): the last 24 bits before the frame clock changes fill sample_o[23:0]. Frame clock high is left.
- R5: Data is taken only on rising bit-clock edges. A data-line change while the bit clock is high has no effect.
- R6: Each complete half-frame that meets its minimum length gives exactly one valid_o pulse, one clock long, with the sample and tag of that half-frame.
- R7: Minimum bit clocks per half-frame: 16 for code 0, 17 for code 1, 16 for code 2 (32 per frame), 24 for code 3 (48 per frame). A shorter half-frame gives no valid_o and sets err_o.
- R8: err_o stays high until reset.
- R9: fmt_i is read only at a frame-clock change and governs the half-frame that starts there. Changes to it within a half-frame do not alter how that half-frame is decoded.
- R10: After reset, sample_o, right_o, valid_o and err_o are 0. The half-frame in progress at reset release is discarded without a strobe or an error.
- R11: In codes 0 and 1, bits after the 24th data bit of a half-frame are ignored. Words shorter than 24 bits are padded with zeros at the LSB end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial bit clock |
| lrck_i | input | 1 | Frame clock / channel select |
| sdin_i | input | 1 | Serial data |
| fmt_i | input | 2 | Framing select (0 LJ, 1 I2S, 2 RJ16, 3 RJ24) |
| sample_o | output | 24 | Received sample, MSB-aligned |
| right_o | output | 1 | 1 when sample_o is the right channel |
| valid_o | output | 1 | One-cycle strobe for a new sample |
| err_o | output | 1 | Sticky flag for a too-short half-frame |

## Verification
A wrong bit count or a misplaced data index shows up as a wrong sample word at the next frame-clock change. That is at most one half-frame plus a few system clocks of pipeline. A lost or duplicated boundary shows up at once as a missing or extra valid strobe, or a swapped channel tag. A minimum-length check that is off by one shows up as err_o rising, or failing to rise, on the exact-minimum and one-short half-frames. A format latched at the wrong time decodes the half-frame with the new framing, so the sample it emits is wrong.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned WORD_W  = 24;
  localparam int unsigned SHORT_W = 16;

  typedef enum logic [1:0] {
    FMT_LJ   = 2'd0,
    FMT_I2S  = 2'd1,
    FMT_RJ16 = 2'd2,
    FMT_RJ24 = 2'd3
  } fmt_e;

  function automatic int unsigned min_bits(fmt_e f);
    case (f)
      FMT_LJ:   return SHORT_W;
      FMT_I2S:  return SHORT_W + 1;
      FMT_RJ16: return SHORT_W;
      default:  return WORD_W;
    endcase
  endfunction

  function automatic logic ch_is_right(fmt_e f, logic lr);
    return (f == FMT_I2S) ? lr : ~lr;
  endfunction
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic lrck_i,
  input  logic sdin_i,
  output logic rise_o,
  output logic lrck_o,
  output logic sdin_o
);
  logic [2:0] last;
  logic       sclk_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    logic [2:0] q;
    logic [2:0] d;
    if (g == 0) begin : g_first
      assign d = {sclk_i, lrck_i, sdin_i};
    end else begin : g_next
      assign d = g_stg[g-1].q;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d;
    end
  end

  assign last = g_stg[STAGES-1].q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= last[2];
  end

  assign rise_o = last[2] & ~sclk_d;
  assign lrck_o = last[1];
  assign sdin_o = last[0];

  a_r5_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/sar_frame_ctl.sv
module sar_frame_ctl
  import sar_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             lrck_i,
  input  fmt_e             fmt_i,
  output logic             bound_o,
  output logic             emit_o,
  output logic             right_o,
  output logic             err_o,
  output fmt_e             fmt_o,
  output logic [CNT_W-1:0] pos_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             seen_q, synced_q, lr_q, err_q;
  logic [CNT_W-1:0] cnt_q;
  fmt_e             fmt_q;
  logic             close, enough, drop;

  assign bound_o = rise_i && seen_q && (lrck_i != lr_q);
  assign close   = bound_o && synced_q;
  assign enough  = int'(cnt_q) >= int'(min_bits(fmt_q));
  assign emit_o  = close && enough;
  assign drop    = close && !enough;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q   <= 1'b0;
      synced_q <= 1'b0;
      lr_q     <= 1'b0;
      err_q    <= 1'b0;
      cnt_q    <= '0;
      fmt_q    <= FMT_LJ;
    end else if (rise_i) begin
      seen_q <= 1'b1;
      lr_q   <= lrck_i;
      if (drop) err_q <= 1'b1;
      if (bound_o) begin
        synced_q <= 1'b1;
        fmt_q    <= fmt_i;
        cnt_q    <= CNT_W'(1);
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign right_o = ch_is_right(fmt_q, lr_q);
  assign err_o   = err_q;
  assign fmt_o   = fmt_q;
  assign pos_o   = cnt_q;

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  a_r9_fmt_only_at_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fmt_q) |-> $past(bound_o));
endmodule

// File: rtl/sar_shift.sv
module sar_shift
  import sar_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              sdin_i,
  input  logic              bound_i,
  input  fmt_e              fmt_new_i,
  input  fmt_e              fmt_cur_i,
  input  logic [CNT_W-1:0]  pos_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned IDX_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sh_q, acc_q;
  logic [IDX_W-1:0]  wr_idx;
  logic              wr_en;
  int                k;

  always_comb begin
    k      = int'(pos_i) - ((fmt_cur_i == FMT_I2S) ? 1 : 0);
    wr_en  = !bound_i && (fmt_cur_i == FMT_LJ || fmt_cur_i == FMT_I2S)
             && k >= 0 && k < int'(WORD_W);
    wr_idx = wr_en ? IDX_W'(int'(WORD_W) - 1 - k) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      acc_q <= '0;
    end else if (rise_i) begin
      sh_q <= {sh_q[WORD_W-2:0], sdin_i};
      if (bound_i)
        acc_q <= (fmt_new_i == FMT_LJ) ? {sdin_i, {(WORD_W-1){1'b0}}} : '0;
      else if (wr_en)
        acc_q[wr_idx] <= sdin_i;
    end
  end

  always_comb begin
    case (fmt_cur_i)
      FMT_RJ16: word_o = {sh_q[SHORT_W-1:0], {(WORD_W-SHORT_W){1'b0}}};
      FMT_RJ24: word_o = sh_q;
      default:  word_o = acc_q;
    endcase
  end

  a_r1_lj_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && bound_i && fmt_new_i == FMT_LJ) |=> acc_q[WORD_W-1] == $past(sdin_i));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sclk_i,
  input  logic        lrck_i,
  input  logic        sdin_i,
  input  logic [1:0]  fmt_i,
  output logic [23:0] sample_o,
  output logic        right_o,
  output logic        valid_o,
  output logic        err_o
);
  logic              rise, lrck_s, sdin_s, bound, emit, right_c;
  fmt_e              fmt_cur, out_fmt_q;
  logic [CNT_W-1:0]  pos;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] sample_q;
  logic              right_q, valid_q;

  sar_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .lrck_i, .sdin_i,
    .rise_o(rise), .lrck_o(lrck_s), .sdin_o(sdin_s)
  );

  sar_frame_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk_i, .rst_ni, .rise_i(rise), .lrck_i(lrck_s), .fmt_i(fmt_e'(fmt_i)),
    .bound_o(bound), .emit_o(emit), .right_o(right_c), .err_o(err_o),
    .fmt_o(fmt_cur), .pos_o(pos)
  );

  sar_shift #(.CNT_W(CNT_W)) u_shift (
    .clk_i, .rst_ni, .rise_i(rise), .sdin_i(sdin_s), .bound_i(bound),
    .fmt_new_i(fmt_e'(fmt_i)), .fmt_cur_i(fmt_cur), .pos_i(pos), .word_o(word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q  <= '0;
      right_q   <= 1'b0;
      valid_q   <= 1'b0;
      out_fmt_q <= FMT_LJ;
    end else begin
      valid_q <= emit;
      if (emit) begin
        sample_q  <= word;
        right_q   <= right_c;
        out_fmt_q <= fmt_cur;
      end
    end
  end

  assign sample_o = sample_q;
  assign right_o  = right_q;
  assign valid_o  = valid_q;

  a_r6_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r3_rj16_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && out_fmt_q == FMT_RJ16) |-> sample_o[7:0] == 8'h00);
  a_r7_no_strobe_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !valid_o);
endmodule

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sclk = 1'b0, lrck = 1'b0, sdin = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic [23:0] sample_o;
  logic        right_o, valid_o, err_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic        m_seen = 0, m_synced = 0, m_lr = 0, exp_err = 0;
  logic [1:0]  m_fmt = 0;
  logic        bits[$];
  logic [23:0] exp_s[$];
  logic        exp_r[$];
  string       exp_t[$];

  always #4 clk = ~clk;

  serial_audio_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .lrck_i(lrck), .sdin_i(sdin),
    .fmt_i(fmt), .sample_o(sample_o), .right_o(right_o), .valid_o(valid_o),
    .err_o(err_o)
  );

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (ok !== 1'b1) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int min_n(logic [1:0] f);
    case (f)
      2'd0: return 16;
      2'd1: return 17;
      2'd2: return 16;
      default: return 24;
    endcase
  endfunction

  task automatic model_close();
    int n;
    logic [23:0] s;
    string t;
    n = bits.size();
    s = '0;
    if (n < min_n(m_fmt)) begin
      exp_err = 1'b1;
      return;
    end
    case (m_fmt)
      2'd0: begin
        for (int i = 0; i < 24 && i < n; i++) s[23-i] = bits[i];
        t = (n > 24) ? "R1 R11" : "R1";
      end
      2'd1: begin
        for (int i = 0; i < 24 && i + 1 < n; i++) s[23-i] = bits[i+1];
        t = (n > 25) ? "R2 R11" : "R2";
      end
      2'd2: begin
        for (int j = 0; j < 16; j++) s[23-j] = bits[n-16+j];
        t = "R3";
      end
      default: begin
        for (int j = 0; j < 24; j++) s[23-j] = bits[n-24+j];
        t = "R4";
      end
    endcase
    exp_s.push_back(s);
    exp_r.push_back((m_fmt == 2'd1) ? m_lr : ~m_lr);
    exp_t.push_back(t);
  endtask

  task automatic model_rise(input logic lr, input logic d);
    if (m_seen && lr != m_lr) begin
      if (m_synced) model_close();
      m_synced = 1'b1;
      m_fmt = fmt;
      bits.delete();
    end
    m_seen = 1'b1;
    m_lr = lr;
    bits.push_back(d);
  endtask

  task automatic bit_out(input logic lr, input logic d);
    @(negedge clk);
    lrck = lr; sdin = d; sclk = 1'b0;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    model_rise(lr, d);
    @(negedge clk);
    sdin = ~d;  // change while clock high: R5
    @(negedge clk);
  endtask

  task automatic send_half(input logic lr, input int n, input logic [63:0] pat);
    for (int i = 0; i < n; i++) bit_out(lr, pat[63-i]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sclk = 1'b0;
    m_seen = 0; m_synced = 0; exp_err = 0;
    bits.delete(); exp_s.delete(); exp_r.delete(); exp_t.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drain(input string tag);
    repeat (8) @(negedge clk);
    chk(exp_s.size() == 0, tag, "samples still pending", exp_s.size(), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o) begin
        if (exp_s.size() == 0) begin
          chk(1'b0, "R6", "unexpected valid", {8'h0, sample_o}, 0);
        end else begin
          logic [23:0] es;
          logic er;
          string et;
          es = exp_s.pop_front(); er = exp_r.pop_front(); et = exp_t.pop_front();
          chk(sample_o == es && right_o == er, {et, " R6"}, "sample/tag",
              {7'h0, right_o, sample_o}, {7'h0, er, es});
        end
      end
      if (err_o && !exp_err) chk(1'b0, "R7", "err without short half-frame", 1, 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(sample_o == 0 && valid_o == 0, "R10", "reset sample/valid", {8'h0, sample_o}, 0);
    chk(right_o == 0 && err_o == 0, "R10", "reset tag/err", {right_o, err_o}, 0);

    // left-justified; first partial half discarded (R10)
    fmt = 2'd0;
    send_half(1, 5, 64'hFFFF_FFFF_FFFF_FFFF);
    send_half(0, 24, 64'hA5C3_1F0E_9B27_64D8);
    chk(valid_o == 0 && err_o == 0 && exp_s.size() == 0, "R10", "partial half ignored",
        {valid_o, err_o}, 0);
    send_half(1, 16, 64'h5A3C_E187_0000_0000);
    send_half(0, 32, 64'h1234_5678_9ABC_DEF0);
    send_half(1, 20, 64'hFEDC_BA98_7654_3210);

    // I2S
    fmt = 2'd1;
    send_half(0, 24, 64'hC0FF_EE12_3456_789A);
    send_half(1, 17, 64'h8001_7FFE_1111_2222);
    send_half(0, 33, 64'h3C3C_A5A5_0F0F_F0F0);
    send_half(1, 25, 64'h6B8D_21F4_AA55_CC33);
    drain("R2");

    // right-justified 16
    fmt = 2'd2;
    send_half(0, 16, 64'hBEEF_0000_0000_0000);
    send_half(1, 20, 64'h7E57_1AB2_0000_0000);
    send_half(0, 32, 64'hDEAD_BEEF_CAFE_F00D);

    // right-justified 24
    fmt = 2'd3;
    send_half(1, 24, 64'h9E37_79B9_7F4A_7C15);
    send_half(0, 48, 64'h0123_4567_89AB_CDEF);
    // R9: format select changes inside the half-frame
    for (int i = 0; i < 30; i++) begin
      if (i == 5) fmt = 2'd0;
      bit_out(1, i[0] ^ i[2] ^ i[3]);
    end
    send_half(0, 24, 64'h2468_ACE1_3579_BDF0);
    drain("R9");

    // R7 / R8: short right-justified 16 half-frame
    chk(err_o == 0, "R7", "no error before short half", err_o, 0);
    fmt = 2'd2;
    send_half(1, 15, 64'hFFFE_0000_0000_0000);
    send_half(0, 16, 64'h4321_0000_0000_0000);
    drain("R7");
    chk(err_o == 1, "R7", "short RJ16 half sets err", err_o, 1);
    send_half(1, 16, 64'h8765_0000_0000_0000);
    send_half(0, 16, 64'h0F0F_0000_0000_0000);
    drain("R8");
    chk(err_o == 1, "R8", "err stays set", err_o, 1);

    // R10 again, then short left-justified half
    do_reset();
    @(negedge clk);
    chk(err_o == 0 && valid_o == 0 && sample_o == 0, "R10", "reset clears err",
        {err_o, valid_o, sample_o}, 0);
    fmt = 2'd0;
    send_half(0, 3, 64'h0);
    send_half(1, 24, 64'h7777_8888_9999_AAAA);
    send_half(0, 15, 64'hFFFF_0000_0000_0000);
    send_half(1, 24, 64'h1357_9BDF_0246_8ACE);
    drain("R7");
    chk(err_o == 1, "R7", "short LJ half sets err", err_o, 1);

    // exact-minimum RJ24 after error
    fmt = 2'd3;
    send_half(0, 24, 64'hABCD_EF01_2345_6789);
    send_half(1, 24, 64'h0000_0000_0000_0000);
    drain("R4");
    finish_run();
  end
endmodule